// File: doc/BRIEF.md
# Third-Order Sinc Decimation Filter

This block turns the single-bit density stream of a second-order delta-sigma modulator into wide integer words delivered at a lower rate. The block is clocked by the modulator clock. The modulator bit is captured on the falling edge of that clock. The captured bit feeds a chain of three running accumulators that advance on every rising edge. A decimation counter divides the rate by a run-time ratio N. Once per N clocks, the value of the last accumulator goes through three cascaded difference stages. The final difference is stored in a 40-bit holding register.

The holding register is read directly, or one byte at a time through a small select input, which suits a slow host that reads the register byte by byte. The ratio is loaded one byte at a time, into either its low byte or its high byte. Every load restarts the filter from a clean state. The first three words after a restart are marked as still settling.

Top module: `sinc3_decim`

## Requirements
- R1: While reset is asserted and directly after it, `result` is 0, `result_vld` and `result_settling` are low, and `rd_byte` is 0. After reset the ratio is 64.
- R2: The bit used by the filter is the level of `mod_bit` at the falling clock edge. A change made just after a rising edge therefore counts for the sample of the following rising edge.
- R3: Number the rising edges after a restart as t = 1, 2, .... Let x(t) be the bit captured at the falling edge just before edge t, and take x as 0 before the restart. The word registered at edge t = kN is the sum over j = 0..3N-3 of h(j)·x(kN-3-j). Here h(j) is the number of ways to write j as a+b+c with each term in 0..N-1.
- R4: `result_vld` is high for exactly one cycle per word. Successive pulses are exactly N clocks apart. The first pulse after a restart follows the restart edge by N clocks.
- R5: A write with `cfg_wr` high loads `cfg_data` into the high byte of the ratio when `cfg_hi` is 1, and into the low byte when it is 0. On the same edge the write clears the counter, all accumulator and difference state, `result`, `result_vld` and `result_settling`.
- R6: The effective N is 1 when the ratio is 0. It is 8192 when the ratio is above 8192. Otherwise it is the ratio.
- R7: `result_settling` is high together with `result_vld` for the first three words after a restart, and low at all other times.
- R8: `rd_byte` shows byte `rd_idx` of `result`, where index 0 is bits 7:0 and index 4 is bits 39:32. It shows 0 for indices 5 to 7.
- R9: `result` changes only on a new word or on a restart. Between those events it holds its value.
- R10: With N = 8192 and a stream of all ones, the fourth and later words equal 2^39 without overflow. No word ever exceeds N^3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_bit | input | 1 | Modulator output bit |
| cfg_wr | input | 1 | Ratio byte write strobe; also restarts the filter |
| cfg_hi | input | 1 | Byte select for the write: 1 high, 0 low |
| cfg_data | input | 8 | Ratio byte to write |
| rd_idx | input | 3 | Byte select for the readout |
| result | output | 40 | Holding register with the latest filter word |
| result_vld | output | 1 | One-cycle pulse marking a new word |
| result_settling | output | 1 | Marks the first three words after a restart |
| rd_byte | output | 8 | Selected byte of the holding register |

## Verification
The hardest corner to reach is the full-scale word at the largest ratio. Reaching it needs more than three complete decimation periods of 8192 clocks with an unbroken run of ones, and the stream must start from a restart. The bench writes the largest ratio and then holds the bit high for four whole words.

Ratios above the limit are reached by writing a high byte that takes the ratio past 8192. A zero ratio is written to exercise the single-sample path, where any slip in the falling-edge alignment shows up directly in the output. A restart in the middle of a word is also driven, to show that a partial accumulation leaves no trace.

// File: rtl/sinc3_decim.sv
module sinc3_decim #(
  parameter int W     = 40,
  parameter int NMAX  = 8192,
  parameter int DEF_N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mod_bit,
  input  logic         cfg_wr,
  input  logic         cfg_hi,
  input  logic [7:0]   cfg_data,
  input  logic [2:0]   rd_idx,
  output logic [W-1:0] result,
  output logic         result_vld,
  output logic         result_settling,
  output logic [7:0]   rd_byte
);
  localparam int CW = $clog2(NMAX);
  localparam int LW = CW + 1;

  logic [15:0]   ratio;
  logic [LW-1:0] eff_n;
  logic [CW-1:0] cnt;
  logic          samp;
  logic          strobe;
  logic [1:0]    words;
  logic [W-1:0]  acc1, acc2, acc3;
  logic [W-1:0]  dly1, dly2, dly3;
  logic [W-1:0]  dif1, dif2, dif3;

  assign eff_n  = (ratio == 16'd0)        ? LW'(1) :
                  (ratio > 16'(NMAX))     ? LW'(NMAX) : ratio[LW-1:0];
  assign strobe = ({1'b0, cnt} + LW'(1)) == eff_n;

  assign dif1 = acc3 - dly1;
  assign dif2 = dif1 - dly2;
  assign dif3 = dif2 - dly3;

  assign rd_byte = 8'(result >> {rd_idx, 3'b000});

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) samp <= 1'b0;
    else        samp <= mod_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio <= 16'(DEF_N);
      cnt <= '0; words <= '0;
      acc1 <= '0; acc2 <= '0; acc3 <= '0;
      dly1 <= '0; dly2 <= '0; dly3 <= '0;
      result <= '0; result_vld <= 1'b0; result_settling <= 1'b0;
    end else if (cfg_wr) begin
      ratio <= cfg_hi ? {cfg_data, ratio[7:0]} : {ratio[15:8], cfg_data};
      cnt <= '0; words <= '0;
      acc1 <= '0; acc2 <= '0; acc3 <= '0;
      dly1 <= '0; dly2 <= '0; dly3 <= '0;
      result <= '0; result_vld <= 1'b0; result_settling <= 1'b0;
    end else begin
      acc1 <= acc1 + W'(samp);
      acc2 <= acc2 + acc1;
      acc3 <= acc3 + acc2;
      cnt  <= strobe ? '0 : cnt + CW'(1);
      result_vld      <= strobe;
      result_settling <= strobe && (words != 2'd3);
      if (strobe) begin
        dly1 <= acc3;
        dly2 <= dif1;
        dly3 <= dif2;
        result <= dif3;
        if (words != 2'd3) words <= words + 2'd1;
      end
    end
  end
endmodule

// File: rtl/sinc3_decim_chk.sv
module sinc3_decim_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic        result_vld,
  input logic        result_settling,
  input logic [39:0] result,
  input logic [13:0] eff_n
);
  logic [14:0] gap;
  logic [63:0] cube;

  assign cube = 64'(eff_n) * 64'(eff_n) * 64'(eff_n);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          gap <= '0;
    else if (cfg_wr)     gap <= '0;
    else if (result_vld) gap <= 15'd1;
    else                 gap <= gap + 15'd1;

  AST_VLD_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld |-> gap == {1'b0, eff_n});  // R4
  AST_CLEAR_ON_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (result == '0 && !result_vld && !result_settling));  // R5
  AST_SETTLE_WITH_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    result_settling |-> result_vld);  // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!result_vld && !$past(cfg_wr)) |-> $stable(result));  // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld |-> {24'd0, result} <= cube);  // R10
endmodule

bind sinc3_decim sinc3_decim_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .result_vld(result_vld),
  .result_settling(result_settling), .result(result), .eff_n(eff_n)
);

// File: tb/sim_sinc3_decim.sv
`timescale 1ns/1ps
module sim_sinc3_decim;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0, mod_bit = 1'b0, cfg_wr = 1'b0, cfg_hi = 1'b0;
  logic [7:0]  cfg_data = 8'd0;
  logic [2:0]  rd_idx = 3'd0;
  logic [39:0] result;
  logic        result_vld, result_settling;
  logic [7:0]  rd_byte;

  sinc3_decim u0 (.clk(clk), .rst_n(rst_n), .mod_bit(mod_bit), .cfg_wr(cfg_wr),
    .cfg_hi(cfg_hi), .cfg_data(cfg_data), .rd_idx(rd_idx), .result(result),
    .result_vld(result_vld), .result_settling(result_settling), .rd_byte(rd_byte));

  bit hist [0:40000];
  int t, k, g, cur_n, mode, total, bad;
  longint last_res;
  string tag = "R3";
  bit finished = 0;

  function automatic longint c2(longint m);
    return (m >= 2) ? m * (m - 1) / 2 : 0;
  endfunction

  function automatic longint coef(longint n, longint j);
    return c2(j + 2) - 3 * c2(j - n + 2) + 3 * c2(j - 2 * n + 2) - c2(j - 3 * n + 2);
  endfunction

  function automatic longint expect_at(int n, int tt);
    longint s = 0;
    for (int j = 0; j <= 3 * n - 3; j++) begin
      int idx = tt - 3 - j;
      if (idx >= 1 && hist[idx]) s += coef(n, j);
    end
    return s;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    bit b;
    longint e;
    @(posedge clk);
    if (cfg_wr) begin t = 0; k = 0; g = 0; last_res = 0; end
    else begin t++; g++; end
    #1;
    cfg_wr = 1'b0;
    case (mode)
      0: b = 1'($urandom % 2);
      1: b = 1'b1;
      2: b = 1'b0;
      default: b = 1'(t);
    endcase
    mod_bit = b;
    hist[t + 1] = b;
    @(negedge clk);
    if (result_vld) begin
      k++;
      e = expect_at(cur_n, t);
      chk(result == e[39:0], tag, longint'(result), e);
      chk(g == cur_n, "R4 gap", g, cur_n);
      chk(result_settling == (k <= 3), "R7", result_settling, k <= 3);
      if (k == 2) begin
        for (int i = 0; i < 8; i++) begin
          longint eb = (i < 5) ? ((e >> (8 * i)) & 255) : 0;
          rd_idx = 3'(i);
          #1;
          chk(rd_byte == eb[7:0], "R8", rd_byte, eb);
        end
        rd_idx = 3'd0;
      end
      last_res = longint'(result);
      g = 0;
    end else if (result != last_res[39:0]) begin
      chk(0, "R9", longint'(result), last_res);
    end
  endtask

  task automatic write_cfg(bit hi, logic [7:0] d, int neff);
    cfg_wr = 1'b1; cfg_hi = hi; cfg_data = d; cur_n = neff;
    step();
    chk(result == 0 && !result_vld && !result_settling, "R5", longint'(result), 0);
  endtask

  task automatic set_ratio(int r, int neff);
    write_cfg(1'b0, r[7:0], neff);
    write_cfg(1'b1, r[15:8], neff);
  endtask

  task automatic run_words(int n);
    while (k < n) step();
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(result == 0 && !result_vld && !result_settling && rd_byte == 0, "R1",
        longint'(result), 0);
    rst_n = 1'b1;
    // default ratio after reset: first word 64 clocks after release
    mode = 2; g = 0;
    while (!result_vld) begin @(posedge clk); g++; @(negedge clk); end
    chk(g == 64, "R1 default ratio", g, 64);

    mode = 3; set_ratio(5, 5);   run_words(6);
    mode = 0; set_ratio(37, 37); run_words(5);
    tag = "R2"; set_ratio(0, 1); run_words(8); tag = "R3";   // R6 zero ratio
    for (int r = 0; r < 4; r++) begin
      int n = 2 + int'($urandom % 200);
      set_ratio(n, n);
      run_words(4);
    end
    set_ratio(20, 20); run_words(1);
    repeat (7) step();
    set_ratio(11, 11); run_words(4);                          // R5 mid-word restart
    mode = 1; set_ratio(8192, 8192); run_words(4);
    chk(result == 40'h80_0000_0000, "R10", longint'(result), 64'h80_0000_0000);
    mode = 0; set_ratio(9000, 8192); run_words(2);            // R6 clamp above limit
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule